// File: doc/BRIEF.md
# Mapping Table Scan Engine

This block sits beside a page mapping table and walks it one entry per clock on command. It runs one of two operations. A clear pass stamps every entry with the invalid marker. A reverse search looks for the lowest-numbered valid entry that holds a given physical page value. The search window depends on the memory kind the caller names. For flash pages the whole table is searched. For external RAM pages only a fixed sub-window of the table is searched, set by two parameters.

The table RAM and its single read/write port live inside the block. While the engine is idle, a host port reaches that RAM directly. Once the engine accepts a start, it takes the port until its done cycle ends. The result (hit flag and entry index) stays registered until the next accepted start.

Top module: `map_scan_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `found_o` are 0 and `index_o` is all ones.
- R2: A start with `op_i`=1 (clear) writes the value with the top bit set and all value bits zero (invalid marker, top bit = invalid flag) into every entry from 0 to DEPTH-1. `done_o` rises DEPTH edges after the start edge, and it reports found 0 with index all ones.
- R3: A start with `op_i`=0 and `target_i`=0 (flash) searches entries 0 to DEPTH-1 for a valid entry whose low VAL_W bits equal `match_val_i`.
- R4: With `target_i`=1 (RAM), the search covers only entries RAM_LO to RAM_HI. Matches outside that window are never reported.
- R5: An entry whose top bit (invalid flag) is set is skipped, even when its value bits equal the key.
- R6: When several entries match, the lowest index in the window is reported.
- R7: When no entry matches, `found_o` is 0 and `index_o` is all ones (one bit wider than an entry address, so it never aliases a real entry).
- R8: A hit at window offset j raises `done_o` j+2 edges after the start edge. A miss over a window of N entries raises it N+1 edges after.
- R9: `busy_o` is high from the edge after an accepted start through the single-cycle `done_o` pulse. A start while busy is ignored.
- R10: While idle, a host write stores its data and a host read returns the entry one edge later. Host writes while busy have no effect.
- R11: `found_o` and `index_o` change only in the cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 1 | 0 = reverse search, 1 = clear all |
| target_i | input | 1 | 0 = flash window, 1 = RAM window |
| match_val_i | input | VAL_W | Physical page value to search for |
| busy_o | output | 1 | Engine owns the table |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Last search hit |
| index_o | output | clog2(DEPTH)+1 | Hit entry index, all ones on miss |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | clog2(DEPTH) | Host entry address |
| host_wdata_i | input | VAL_W+1 | Host write data, top bit = invalid flag |
| host_rdata_o | output | VAL_W+1 | Entry read one edge after address |

## Verification
The bench builds the engine with a 64-entry table, 4-bit page values and a RAM window of entries 48 to 55. At that size it can sweep every page value in both windows and recompute each expected index and latency by scanning its own copy of the table. It can also read back the whole table after a clear. Because 64 is a power of two, a miss must be told apart from a hit on the last entry, and a start and a host write can be placed inside a busy scan at a known cycle.

// File: rtl/map_scan_pkg.sv
package map_scan_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_DONE  = 2'd3
   } scan_state_e;

   typedef enum logic {
      OP_LOOKUP = 1'b0,
      OP_CLEAR  = 1'b1
   } scan_op_e;

   typedef enum logic {
      TGT_FLASH = 1'b0,
      TGT_RAM   = 1'b1
   } scan_tgt_e;
endpackage

// File: rtl/map_scan_table.sv
// Single-port synchronous table RAM, read-before-write, no reset on contents.
module map_scan_table #(
   parameter int DEPTH = 2048,
   parameter int ENT_W = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [ENT_W-1:0] wdata_i,
   output logic [ENT_W-1:0] rdata_o
);
   logic [ENT_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      rdata_o <= mem_q[addr_i];
   end
endmodule

// File: rtl/map_scan_match.sv
// One-stage compare: tags each issued read so the hit carries the index that produced it.
module map_scan_match #(
   parameter int VAL_W = 8,
   parameter int AW    = 11
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue_vld_i,
   input  logic [AW-1:0]  issue_idx_i,
   input  logic [VAL_W-1:0] key_i,
   input  logic [VAL_W:0] entry_i,
   output logic           hit_o,
   output logic [AW-1:0]  hit_idx_o
);
   logic          tag_vld_q;
   logic [AW-1:0] tag_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_vld_q <= 1'b0;
         tag_idx_q <= '0;
      end else begin
         tag_vld_q <= issue_vld_i;
         tag_idx_q <= issue_idx_i;
      end
   end

   // top bit of an entry is the invalid flag
   assign hit_o     = tag_vld_q && !entry_i[VAL_W] && (entry_i[VAL_W-1:0] == key_i);
   assign hit_idx_o = tag_idx_q;
endmodule

// File: rtl/map_scan_ctrl.sv
module map_scan_ctrl
   import map_scan_pkg::*;
#(
   parameter int DEPTH  = 2048,
   parameter int VAL_W  = 8,
   parameter int RAM_LO = 1152,
   parameter int RAM_HI = 1279,
   parameter int AW     = 11,
   parameter int IDX_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_i,
   input  logic             tgt_i,
   input  logic [VAL_W-1:0] key_i,
   input  logic             hit_i,
   input  logic [AW-1:0]    hit_idx_i,
   output logic             eng_we_o,
   output logic [AW-1:0]    eng_addr_o,
   output logic [VAL_W:0]   eng_wdata_o,
   output logic             issue_vld_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             found_o,
   output logic [IDX_W-1:0] index_o,
   output logic [VAL_W-1:0] key_o,
   output logic             tgt_o
);
   localparam logic [AW-1:0]    LAST_ALL  = AW'(DEPTH - 1);
   localparam logic [IDX_W-1:0] MISS_IDX  = '1;

   logic [AW-1:0] win_first, win_last;

   // window bounds: a window spanning the whole table collapses to the flash bounds
   generate
      if (RAM_LO == 0 && RAM_HI == DEPTH - 1) begin : g_full_win
         assign win_first = '0;
         assign win_last  = LAST_ALL;
      end else begin : g_split_win
         assign win_first = (op_i == OP_LOOKUP && tgt_i == TGT_RAM) ? AW'(RAM_LO) : '0;
         assign win_last  = (op_i == OP_LOOKUP && tgt_i == TGT_RAM) ? AW'(RAM_HI) : LAST_ALL;
      end
   endgenerate

   scan_state_e   state_q;
   scan_op_e      op_q;
   logic [AW-1:0] addr_q, last_q;
   logic [VAL_W-1:0] key_q;
   logic          tgt_q;
   logic          found_q;
   logic [IDX_W-1:0] index_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_LOOKUP;
         addr_q  <= '0;
         last_q  <= '0;
         key_q   <= '0;
         tgt_q   <= 1'b0;
         found_q <= 1'b0;
         index_q <= MISS_IDX;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q    <= scan_op_e'(op_i);
                  tgt_q   <= tgt_i;
                  key_q   <= key_i;
                  addr_q  <= win_first;
                  last_q  <= win_last;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (op_q == OP_LOOKUP && hit_i) begin
                  found_q <= 1'b1;
                  index_q <= IDX_W'(hit_idx_i);
                  state_q <= ST_DONE;
               end else if (addr_q == last_q) begin
                  if (op_q == OP_CLEAR) begin
                     found_q <= 1'b0;
                     index_q <= MISS_IDX;
                     state_q <= ST_DONE;
                  end else begin
                     state_q <= ST_DRAIN;
                  end
               end else begin
                  addr_q <= addr_q + AW'(1);
               end
            end
            ST_DRAIN: begin
               found_q <= hit_i;
               index_q <= hit_i ? IDX_W'(hit_idx_i) : MISS_IDX;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign eng_we_o    = (state_q == ST_SCAN) && (op_q == OP_CLEAR);
   assign issue_vld_o = (state_q == ST_SCAN) && (op_q == OP_LOOKUP);
   assign eng_addr_o  = addr_q;
   assign eng_wdata_o = {1'b1, {VAL_W{1'b0}}};
   assign found_o     = found_q;
   assign index_o     = index_q;
   assign key_o       = key_q;
   assign tgt_o       = tgt_q;
endmodule

// File: rtl/map_scan_engine.sv
module map_scan_engine #(
   parameter int DEPTH  = 2048,
   parameter int VAL_W  = 8,
   parameter int RAM_LO = 1152,
   parameter int RAM_HI = 1279,
   localparam int AW    = $clog2(DEPTH),
   localparam int IDX_W = AW + 1,
   localparam int ENT_W = VAL_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_i,
   input  logic             target_i,
   input  logic [VAL_W-1:0] match_val_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             found_o,
   output logic [IDX_W-1:0] index_o,
   input  logic             host_we_i,
   input  logic [AW-1:0]    host_addr_i,
   input  logic [ENT_W-1:0] host_wdata_i,
   output logic [ENT_W-1:0] host_rdata_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("map_scan_engine: DEPTH must be at least 2");
      end
      if (VAL_W < 1) begin : g_bad_width
         $error("map_scan_engine: VAL_W must be at least 1");
      end
      if (RAM_LO > RAM_HI || RAM_HI >= DEPTH || RAM_LO < 0) begin : g_bad_window
         $error("map_scan_engine: RAM window must satisfy 0 <= RAM_LO <= RAM_HI < DEPTH");
      end
   endgenerate

   logic             eng_we, issue_vld, hit, tgt_q;
   logic [AW-1:0]    eng_addr, hit_idx;
   logic [ENT_W-1:0] eng_wdata, ram_rdata;
   logic [VAL_W-1:0] key_q;
   logic             ram_we;
   logic [AW-1:0]    ram_addr;
   logic [ENT_W-1:0] ram_wdata;

   map_scan_ctrl #(
      .DEPTH(DEPTH), .VAL_W(VAL_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
      .AW(AW), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_i),
      .tgt_i      (target_i),
      .key_i      (match_val_i),
      .hit_i      (hit),
      .hit_idx_i  (hit_idx),
      .eng_we_o   (eng_we),
      .eng_addr_o (eng_addr),
      .eng_wdata_o(eng_wdata),
      .issue_vld_o(issue_vld),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .found_o    (found_o),
      .index_o    (index_o),
      .key_o      (key_q),
      .tgt_o      (tgt_q)
   );

   // the engine owns the table port whenever it is busy
   assign ram_we    = busy_o ? eng_we    : host_we_i;
   assign ram_addr  = busy_o ? eng_addr  : host_addr_i;
   assign ram_wdata = busy_o ? eng_wdata : host_wdata_i;

   map_scan_table #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_table (
      .clk    (clk),
      .we_i   (ram_we),
      .addr_i (ram_addr),
      .wdata_i(ram_wdata),
      .rdata_o(ram_rdata)
   );

   map_scan_match #(.VAL_W(VAL_W), .AW(AW)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_vld_i(issue_vld),
      .issue_idx_i(eng_addr),
      .key_i      (key_q),
      .entry_i    (ram_rdata),
      .hit_o      (hit),
      .hit_idx_o  (hit_idx)
   );

   assign host_rdata_o = ram_rdata;
endmodule

// File: rtl/map_scan_engine_chk.sv
module map_scan_engine_chk #(
   parameter int DEPTH  = 2048,
   parameter int RAM_LO = 1152,
   parameter int RAM_HI = 1279,
   parameter int IDX_W  = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_i,
   input logic             done_i,
   input logic             found_i,
   input logic [IDX_W-1:0] index_i,
   input logic             tgt_ram_i,
   input logic             eng_we_i,
   input logic             issue_vld_i
);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !done_i);

   a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> busy_i);

   a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> $past(start_i));

   a_r9_port_use_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_we_i || issue_vld_i) |-> busy_i);

   a_r7_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !found_i) |-> (index_i == {IDX_W{1'b1}}));

   a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |-> ($stable(index_i) && $stable(found_i)));

   a_r4_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && found_i && tgt_ram_i) |->
         (index_i >= IDX_W'(RAM_LO) && index_i <= IDX_W'(RAM_HI)));

   a_r3_hit_in_table: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && found_i) |-> (index_i < IDX_W'(DEPTH)));
endmodule

bind map_scan_engine map_scan_engine_chk #(
   .DEPTH(DEPTH), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .busy_i     (busy_o),
   .done_i     (done_o),
   .found_i    (found_o),
   .index_i    (index_o),
   .tgt_ram_i  (tgt_q),
   .eng_we_i   (eng_we),
   .issue_vld_i(issue_vld)
);

// File: tb/map_scan_engine_tb_top.sv
module map_scan_engine_tb_top;
   localparam int DEPTH  = 64;
   localparam int VAL_W  = 4;
   localparam int RAM_LO = 48;
   localparam int RAM_HI = 55;
   localparam int AW     = 6;
   localparam int IDX_W  = 7;
   localparam logic [IDX_W-1:0] MISS = '1;
   localparam logic [VAL_W:0]   INV  = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, op_i = 1'b0, target_i = 1'b0;
   logic [VAL_W-1:0] match_val_i = '0;
   logic busy_o, done_o, found_o;
   logic [IDX_W-1:0] index_o;
   logic host_we_i = 1'b0;
   logic [AW-1:0] host_addr_i = '0;
   logic [VAL_W:0] host_wdata_i = '0;
   logic [VAL_W:0] host_rdata_o;

   always #10 clk = ~clk;

   map_scan_engine #(.DEPTH(DEPTH), .VAL_W(VAL_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .target_i(target_i),
      .match_val_i(match_val_i), .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
      .index_o(index_o), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
      .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [VAL_W:0] model [DEPTH];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic hwrite(input int a, input logic [VAL_W:0] d);
      @(negedge clk);
      host_we_i = 1'b1; host_addr_i = AW'(a); host_wdata_i = d;
      @(negedge clk);
      host_we_i = 1'b0;
      model[a] = d;
   endtask

   task automatic hread(input int a, output logic [VAL_W:0] d);
      @(negedge clk);
      host_addr_i = AW'(a);
      @(negedge clk);
      d = host_rdata_o;
   endtask

   // issue one operation; lat = edges from the start edge to the done cycle
   task automatic run(input logic op, input logic tgt, input logic [VAL_W-1:0] v, output int lat);
      @(negedge clk);
      start_i = 1'b1; op_i = op; target_i = tgt; match_val_i = v;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!done_o && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   // expected search result from the bench's own copy of the table
   function automatic int expect_idx(input logic tgt, input logic [VAL_W-1:0] v);
      int lo = tgt ? RAM_LO : 0;
      int hi = tgt ? RAM_HI : DEPTH - 1;
      for (int i = lo; i <= hi; i++)
         if (!model[i][VAL_W] && model[i][VAL_W-1:0] == v) return i;
      return -1;
   endfunction

   task automatic check_search(input logic tgt, input logic [VAL_W-1:0] v, input string tag);
      int lat, e, lo, n, elat;
      lo = tgt ? RAM_LO : 0;
      n  = tgt ? (RAM_HI - RAM_LO + 1) : DEPTH;
      e  = expect_idx(tgt, v);
      elat = (e < 0) ? n + 1 : (e - lo + 2);
      run(1'b0, tgt, v, lat);
      if (e < 0) begin
         chk(!found_o, {tag, " R7 found"}, found_o, 0);
         chk(index_o == MISS, {tag, " R7 index"}, index_o, MISS);
      end else begin
         chk(found_o, {tag, " R6 found"}, found_o, 1);
         chk(index_o == IDX_W'(e), {tag, " R6 index"}, index_o, e);
      end
      chk(lat == elat, {tag, " R8 latency"}, lat, elat);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      finish_run();
   end

   initial begin
      int lat;
      logic [VAL_W:0] d;
      bit all_inv;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o, "R1 busy/done", {busy_o, done_o}, 0);
      chk(!found_o, "R1 found", found_o, 0);
      chk(index_o == MISS, "R1 index", index_o, MISS);
      rst_n = 1'b1;
      @(negedge clk);

      // fill: value (5i+3) mod 16, invalid when i%3==0 or value is 15
      for (int i = 0; i < DEPTH; i++) begin
         logic [VAL_W-1:0] v = VAL_W'((i * 5 + 3) % 16);
         hwrite(i, {(i % 3 == 0) || (v == 4'hF), v});
      end
      hread(10, d);
      chk(d == model[10], "R10 idle host readback", d, model[10]);

      // R3 R5 R6 flash window sweep, R4 RAM window sweep
      for (int v = 0; v < 16; v++) check_search(1'b0, VAL_W'(v), "R3 flash sweep");
      for (int v = 0; v < 16; v++) check_search(1'b1, VAL_W'(v), "R4 ram sweep");

      // R2 clear all entries
      run(1'b1, 1'b0, '0, lat);
      chk(lat == DEPTH, "R2 clear latency", lat, DEPTH);
      chk(!found_o && index_o == MISS, "R2 clear result", index_o, MISS);
      all_inv = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         hread(i, d);
         if (d != INV) all_inv = 1'b0;
         model[i] = INV;
      end
      chk(all_inv, "R2 every entry invalid", all_inv, 1);
      check_search(1'b0, 4'h0, "R2 search after clear");

      // R5 invalid match skipped, R6 lowest of two
      hwrite(7,  {1'b1, 4'h6});
      hwrite(20, {1'b0, 4'h6});
      hwrite(30, {1'b0, 4'h6});
      check_search(1'b0, 4'h6, "R5 skip invalid");
      chk(index_o == 7'd20, "R5 index past invalid", index_o, 20);
      check_search(1'b1, 4'h6, "R4 outside window ignored");
      hwrite(50, {1'b0, 4'h6});
      check_search(1'b1, 4'h6, "R4 in window");
      chk(index_o == 7'd50, "R4 index", index_o, 50);
      hwrite(63, {1'b0, 4'h9});
      check_search(1'b0, 4'h9, "R7 last entry not miss");

      // R11 result held while idle
      repeat (5) @(negedge clk);
      chk(found_o && index_o == 7'd63, "R11 hold", index_o, 63);

      // R9 start and R10 host write while busy ignored
      @(negedge clk);
      start_i = 1'b1; op_i = 1'b0; target_i = 1'b0; match_val_i = 4'h6;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o, "R9 busy after start", busy_o, 1);
      lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      start_i = 1'b1; op_i = 1'b1;
      host_we_i = 1'b1; host_addr_i = 6'd30; host_wdata_i = {1'b0, 4'h2};
      @(negedge clk); lat++;
      start_i = 1'b0; host_we_i = 1'b0;
      while (!done_o && lat < 2000) begin @(negedge clk); lat++; end
      chk(busy_o, "R9 busy in done cycle", busy_o, 1);
      chk(lat == 22, "R9 latency unchanged", lat, 22);
      chk(found_o && index_o == 7'd20, "R9 result", index_o, 20);
      @(negedge clk);
      chk(!busy_o && !done_o, "R9 done single cycle", {busy_o, done_o}, 0);
      repeat (3) @(negedge clk);
      chk(!done_o, "R9 ignored start no second pass", done_o, 0);
      hread(20, d);
      chk(d == {1'b0, 4'h6}, "R9 no clear from ignored start", d, {1'b0, 4'h6});
      hread(30, d);
      chk(d == {1'b0, 4'h6}, "R10 busy host write ignored", d, {1'b0, 4'h6});

      finish_run();
   end
endmodule